// File: doc/BRIEF.md
# Watchdog Timer with Startup Delay

This block watches a software heartbeat line. Each rising or falling edge on the heartbeat input restarts a timeout that is counted in ticks of an external prescaler. If no edge arrives before the timeout ends, the block latches a sticky expiry flag. When the reset-output enable is set, it also drives a reset pulse of fixed length. After that pulse it goes back to its startup phase, so the restarted software gets the long first period again.

The watchdog runs in one of two modes. In independent mode it arms as soon as reset is released. In dependent mode it stays idle until the power sequencer reports that power-up is complete, and it returns to idle if that report is withdrawn. A 3-bit startup code selects a longer first period, and a code of zero means the first period is a normal one. The controller has four states. WD_IDLE is disarmed and leaves on arm, going to WD_START when the startup code is nonzero and to WD_RUN otherwise. WD_START counts the first period and leaves on an edge to WD_RUN, on expiry to WD_PULSE or WD_RUN, and on disarm to WD_IDLE. WD_RUN counts the normal period and makes the same expiry and disarm transitions. WD_PULSE holds the reset and, when its length is done, returns to WD_IDLE.

Top module: `wdog_top`

## Requirements
- R1: While reset is held and on the first cycle after it, `wd_flag` and `wd_rst` are both 0.
- R2: With `cfg_indep`=1 the watchdog arms on the first clock after reset. With `cfg_indep`=0 it never expires while `seq_done` is 0, and it arms on the first clock at which `seq_done` is 1.
- R3: When `cfg_start_code` is nonzero, the first period after arming lasts `cfg_start_code`*START_UNIT ticks. When the code is 0, the first period is the normal timeout.
- R4: The normal timeout is (`cfg_tmo_code`+1)*TMO_UNIT ticks. Any change of `wdi` restarts it, and a change during the startup period switches the watchdog to the normal timeout.
- R5: When `cfg_rst_en`=1, expiry drives `wd_rst` high for exactly RST_CYC clocks, starting on the clock edge that samples the final tick. The watchdog then re-arms through its startup phase.
- R6: When `cfg_rst_en`=0, expiry leaves `wd_rst` at 0 and immediately starts a new normal period.
- R7: `wd_flag` is set on the clock edge of any expiry and stays set until a clock at which `flag_clr`=1. If an expiry happens on that same clock, the set takes priority.
- R8: In dependent mode, a 0 on `seq_done` disarms the watchdog and discards the count. Re-arming starts from the startup phase.
- R9: When a `wdi` change and the tick that would end the period arrive on the same clock, the change wins and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Prescaler tick, one clock wide, advances the timeout |
| wdi | input | 1 | Heartbeat input; either edge counts as service |
| seq_done | input | 1 | Power-up sequence complete, used in dependent mode |
| cfg_indep | input | 1 | 1 = independent mode, 0 = dependent mode |
| cfg_start_code | input | START_CW | Startup-period code, 0 = no startup period |
| cfg_tmo_code | input | TMO_CW | Normal timeout code |
| cfg_rst_en | input | 1 | 1 = expiry drives the reset pulse |
| flag_clr | input | 1 | Write-one-to-clear strobe for the expiry flag |
| wd_flag | output | 1 | Sticky expiry flag |
| wd_rst | output | 1 | Reset pulse, active high |

## Verification
The directed patterns measure the expiry instant against closed-form tick counts. A steady tick with no service separates the normal length from the startup length. A single early edge shows whether the watchdog leaves the startup phase. An edge placed exactly on the final tick shows which of the two has priority. Dependent-mode runs hold `seq_done` low and then drop it part-way through a count, which shows whether the arm condition gates the count and whether that count is discarded. A long random pattern then varies tick density, heartbeat toggles, configuration and clear strobes, while a behavioural model compares both outputs on every clock.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_START = 2'd1,
        WD_RUN   = 2'd2,
        WD_PULSE = 2'd3
    } wd_state_t;
endpackage

// File: rtl/wdog_edge.sv
module wdog_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic edge_o
);
    logic din_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) din_q <= 1'b0;
        else        din_q <= din;
    end

    assign edge_o = din ^ din_q;
endmodule

// File: rtl/wdog_limits.sv
module wdog_limits #(
    parameter int TMO_CW     = 3,
    parameter int START_CW   = 3,
    parameter int TMO_UNIT   = 4,
    parameter int START_UNIT = 8,
    parameter int CW         = 6
) (
    input  logic [TMO_CW-1:0]   tmo_code,
    input  logic [START_CW-1:0] start_code,
    output logic [CW-1:0]       tmo_lim,
    output logic [CW-1:0]       start_lim,
    output logic                start_en
);
    always_comb begin
        int t;
        int s;
        t = (int'(tmo_code) + 1) * TMO_UNIT;
        s = int'(start_code) * START_UNIT;
        tmo_lim   = t[CW-1:0];
        start_lim = s[CW-1:0];
        start_en  = (start_code != '0);
    end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int TMO_CW     = 3,
    parameter int START_CW   = 3,
    parameter int TMO_UNIT   = 4,
    parameter int START_UNIT = 8,
    parameter int RST_CYC    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                wdi,
    input  logic                seq_done,
    input  logic                cfg_indep,
    input  logic [START_CW-1:0] cfg_start_code,
    input  logic [TMO_CW-1:0]   cfg_tmo_code,
    input  logic                cfg_rst_en,
    input  logic                flag_clr,
    output logic                wd_flag,
    output logic                wd_rst
);
    localparam int TMO_MAX   = (2 ** TMO_CW) * TMO_UNIT;
    localparam int START_MAX = (2 ** START_CW - 1) * START_UNIT;
    localparam int MAXT      = (TMO_MAX > START_MAX) ? TMO_MAX : START_MAX;
    localparam int CW        = $clog2(MAXT + 1);
    localparam int PCW       = $clog2(RST_CYC + 1);

    wd_state_t       state, state_n;
    logic [CW-1:0]   cnt, cnt_n;
    logic [PCW-1:0]  pcnt, pcnt_n;
    logic [CW-1:0]   tmo_lim, start_lim, lim;
    logic            start_en, svc_edge, armed, expire, last_tick;

    wdog_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (wdi),
        .edge_o(svc_edge)
    );

    wdog_limits #(
        .TMO_CW    (TMO_CW),
        .START_CW  (START_CW),
        .TMO_UNIT  (TMO_UNIT),
        .START_UNIT(START_UNIT),
        .CW        (CW)
    ) u_lim (
        .tmo_code  (cfg_tmo_code),
        .start_code(cfg_start_code),
        .tmo_lim   (tmo_lim),
        .start_lim (start_lim),
        .start_en  (start_en)
    );

    assign armed     = cfg_indep | seq_done;
    assign lim       = (state == WD_START) ? start_lim : tmo_lim;
    assign last_tick = ({1'b0, cnt} + 1'b1) >= {1'b0, lim};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WD_IDLE;
            cnt   <= '0;
            pcnt  <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            pcnt  <= pcnt_n;
        end
    end

    // next-state logic
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        pcnt_n  = pcnt;
        expire  = 1'b0;
        unique case (state)
            WD_IDLE: begin
                cnt_n = '0;
                if (armed) state_n = start_en ? WD_START : WD_RUN;
            end
            WD_START, WD_RUN: begin
                if (!armed) begin
                    state_n = WD_IDLE;
                    cnt_n   = '0;
                end else if (svc_edge) begin
                    state_n = WD_RUN;
                    cnt_n   = '0;
                end else if (tick) begin
                    if (last_tick) begin
                        expire  = 1'b1;
                        cnt_n   = '0;
                        pcnt_n  = '0;
                        state_n = cfg_rst_en ? WD_PULSE : WD_RUN;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            WD_PULSE: begin
                if (pcnt == PCW'(RST_CYC - 1)) state_n = WD_IDLE;
                else                           pcnt_n  = pcnt + 1'b1;
            end
            default: state_n = WD_IDLE;
        endcase
    end

    // sticky flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        wd_flag <= 1'b0;
        else if (expire)   wd_flag <= 1'b1;
        else if (flag_clr) wd_flag <= 1'b0;
    end

    // outputs
    always_comb begin
        wd_rst = (state == WD_PULSE);
    end
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
    parameter int RST_CYC = 5
) (
    input logic clk,
    input logic rst_n,
    input logic wdi,
    input logic seq_done,
    input logic cfg_indep,
    input logic cfg_rst_en,
    input logic flag_clr,
    input logic wd_flag,
    input logic wd_rst
);
    logic [15:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_len <= '0;
        else if (wd_rst) run_len <= run_len + 16'd1;
        else             run_len <= '0;
    end

    a_r1_rst_idle: assert property (@(posedge clk) !rst_n |-> (!wd_rst && !wd_flag));

    a_r2_dep_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_indep && !seq_done && !wd_rst) |=> !wd_rst);

    a_r5_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_rst) |-> (run_len == 16'(RST_CYC)));

    a_r5_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= 16'(RST_CYC));

    a_r6_rst_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_rst) |-> $past(cfg_rst_en));

    a_r7_flag_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_rst) |-> wd_flag);

    a_r7_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_flag) |-> $past(flag_clr));

    a_r9_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_rst && (wdi != $past(wdi))) |=> !wd_rst);
endmodule

bind wdog_top wdog_chk #(.RST_CYC(RST_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wdi       (wdi),
    .seq_done  (seq_done),
    .cfg_indep (cfg_indep),
    .cfg_rst_en(cfg_rst_en),
    .flag_clr  (flag_clr),
    .wd_flag   (wd_flag),
    .wd_rst    (wd_rst)
);

// File: tb/sim_wdog_top.sv
module sim_wdog_top;
    localparam int TMO_UNIT   = 4;
    localparam int START_UNIT = 8;
    localparam int RST_CYC    = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, wdi = 1'b0, seq_done = 1'b0;
    logic       cfg_indep = 1'b1, cfg_rst_en = 1'b1, flag_clr = 1'b0;
    logic [2:0] cfg_start_code = 3'd0, cfg_tmo_code = 3'd1;
    logic       wd_flag, wd_rst;

    int checks = 0, fails = 0, cycles = 0;
    bit done = 0;

    // behavioural reference
    int m_st = 0, m_cnt = 0, m_p = 0;
    bit m_flag = 0, m_prev = 0;

    always #2 clk = ~clk;

    wdog_top #(.TMO_UNIT(TMO_UNIT), .START_UNIT(START_UNIT), .RST_CYC(RST_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wdi(wdi), .seq_done(seq_done),
        .cfg_indep(cfg_indep), .cfg_start_code(cfg_start_code), .cfg_tmo_code(cfg_tmo_code),
        .cfg_rst_en(cfg_rst_en), .flag_clr(flag_clr), .wd_flag(wd_flag), .wd_rst(wd_rst)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_p = 0; m_flag = 0; m_prev = 0;
        end else begin
            bit arm, chg, exp_now;
            int period;
            arm = cfg_indep || seq_done;
            chg = (wdi != m_prev);
            exp_now = 0;
            period = (m_st == 1) ? cfg_start_code * START_UNIT : (cfg_tmo_code + 1) * TMO_UNIT;
            if (m_st == 0) begin
                m_cnt = 0;
                if (arm) m_st = (cfg_start_code != 0) ? 1 : 2;
            end else if (m_st == 3) begin
                if (m_p == RST_CYC - 1) m_st = 0;
                else m_p++;
            end else if (!arm) begin
                m_st = 0; m_cnt = 0;
            end else if (chg) begin
                m_st = 2; m_cnt = 0;
            end else if (tick) begin
                if (m_cnt + 1 >= period) begin
                    exp_now = 1; m_cnt = 0; m_p = 0;
                    m_st = cfg_rst_en ? 3 : 2;
                end else m_cnt++;
            end
            if (exp_now) m_flag = 1;
            else if (flag_clr) m_flag = 0;
            m_prev = wdi;
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (rst_n && !done) begin
            chk(wd_rst == (m_st == 3), "R5 model wd_rst", wd_rst, m_st == 3);
            chk(wd_flag == m_flag, "R7 model wd_flag", wd_flag, m_flag);
        end
        if (cycles > 150000 && !done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; wdi = 0; flag_clr = 0; seq_done = 0; tick = 1;
        repeat (3) @(negedge clk);
        chk(!wd_rst && !wd_flag, "R1 during reset", {wd_rst, wd_flag}, 0);
        rst_n = 1;
    endtask

    task automatic wait_rst(input int maxc, output int n);
        n = 0;
        while (!wd_rst && n < maxc) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic pulse_len(output int k);
        k = 0;
        while (wd_rst && k < 100) begin
            @(negedge clk);
            k++;
        end
    endtask

    initial begin
        int n, k, highs;

        // R1 / R4 / R5: independent, no startup, normal 8 ticks
        cfg_indep = 1; cfg_rst_en = 1; cfg_start_code = 0; cfg_tmo_code = 1;
        do_reset();
        @(negedge clk);
        chk(!wd_rst && !wd_flag, "R1 after reset", {wd_rst, wd_flag}, 0);
        wait_rst(100, n);
        chk(n == 8, "R4 normal timeout", n + 1, 9);
        chk(wd_flag, "R7 flag on expiry", wd_flag, 1);
        pulse_len(k);
        chk(k == RST_CYC, "R5 pulse length", k, RST_CYC);

        // R3 / R5: startup code 2 -> 16 ticks, again after pulse
        cfg_start_code = 2; cfg_tmo_code = 0;
        do_reset();
        wait_rst(100, n);
        chk(n == 17, "R3 startup period", n, 17);
        pulse_len(k);
        wait_rst(100, n);
        chk(n == 17, "R5 startup re-entered", n, 17);

        // R4: edge during startup switches to normal period
        cfg_start_code = 3; cfg_tmo_code = 0;
        do_reset();
        repeat (2) @(negedge clk);
        wdi = 1;
        wait_rst(100, n);
        chk(n == 5, "R4 edge leaves startup", n, 5);

        // R4: periodic service prevents expiry
        cfg_start_code = 0; cfg_tmo_code = 1;
        do_reset();
        highs = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (i % 5 == 4) wdi = ~wdi;
            if (wd_rst) highs++;
        end
        chk(highs == 0 && !wd_flag, "R4 serviced no expiry", highs, 0);

        // R9: edge on the final tick wins
        cfg_tmo_code = 0;
        do_reset();
        repeat (4) @(negedge clk);
        wdi = 1;
        wait_rst(100, n);
        chk(n == 5, "R9 edge beats final tick", n, 5);

        // R2: dependent mode waits for seq_done
        cfg_indep = 0; cfg_tmo_code = 1;
        do_reset();
        highs = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (wd_rst || wd_flag) highs++;
        end
        chk(highs == 0, "R2 dependent idle", highs, 0);
        seq_done = 1;
        wait_rst(100, n);
        chk(n == 9, "R2 arms on seq_done", n, 9);

        // R8: seq_done drop discards count
        do_reset();
        seq_done = 1;
        repeat (5) @(negedge clk);
        seq_done = 0;
        repeat (10) @(negedge clk);
        chk(!wd_rst, "R8 disarmed", wd_rst, 0);
        seq_done = 1;
        wait_rst(100, n);
        chk(n == 9, "R8 count restarts", n, 9);

        // R6 / R7: no reset output, flag sticky then cleared
        cfg_indep = 1; cfg_rst_en = 0; cfg_tmo_code = 0;
        do_reset();
        highs = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (wd_rst) highs++;
        end
        chk(highs == 0, "R6 reset output gated", highs, 0);
        chk(wd_flag, "R7 flag sticky", wd_flag, 1);
        tick = 0;
        repeat (2) @(negedge clk);
        chk(wd_flag, "R7 flag held", wd_flag, 1);
        flag_clr = 1;
        @(negedge clk);
        flag_clr = 0;
        chk(!wd_flag, "R7 flag cleared", wd_flag, 0);
        tick = 1;

        // random phase compared against the model every clock
        cfg_rst_en = 1;
        do_reset();
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            tick = ($urandom % 3) != 0;
            if ($urandom % 14 == 0) wdi = ~wdi;
            if ($urandom % 60 == 0) seq_done = ~seq_done;
            flag_clr = ($urandom % 40) == 0;
            if ($urandom % 400 == 0) begin
                cfg_indep = $urandom;
                cfg_rst_en = $urandom;
                cfg_start_code = $urandom;
                cfg_tmo_code = $urandom;
            end
        end
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule